// File: doc/BRIEF.md
# Binary-Weighted Bit-Plane LED Sequencer

This block drives 32 LED channels through an external shift-register chain using binary code modulation. A frame of 32 brightness words arrives over a valid/ready stream. The block turns those words into bit-planes. Each plane is one 32-bit word in which bit j is one bit of channel j's brightness. The sequencer then shows the planes one after another. Each plane stays on for a number of timer ticks that doubles with its bit weight. A one-cycle latch strobe marks each plane change. Planes are presented in parallel on `plane_out`, ready for a serializer outside this block.

The frame input follows valid/ready rules. The sender raises `in_valid` with the whole frame on `in_data` and holds both steady until `in_ready` is seen high. The frame is taken on the rising clock edge where both are high. `in_ready` then stays low while the frame waits for the transposer and while the transposer works, one plane per cycle. Once the new planes are complete, `in_ready` rises again. A frame accepted during the sequence is held in a shadow set of planes and is only put on display when plane 0 next begins. If several frames complete before that point, the newest one wins.

A one-cycle `adc_trig` pulse is issued a fixed number of ticks before the longest (most significant) plane ends. A supply or temperature measurement can use it to sample while the output is in its longest steady period. `tick` is a clock enable for all sequencing time.

Top module: `bcm_driver`

## Requirements
- R1: A frame is taken on a clock edge where `in_valid` and `in_ready` are both high. From the next cycle on, `in_ready` is low for exactly NPLANE+1 cycles (15 by default), and then returns high.
- R2: Word j of the frame is `in_data[16j+15:16j]`. Plane i (0 to 13) carries bit i+2 of word j at bit j. The two lowest bits of every word have no effect on any plane.
- R3: Plane 0 is shown first. Plane i lasts 4·2^i ticks, and plane 13 is followed by plane 0 again.
- R4: `strobe` is high for exactly one clock cycle. That cycle is the one in which `plane_out` first shows a new plane. `plane_out` never changes in any other cycle.
- R5: `adc_trig` is a single-cycle pulse, issued once per sequence. It fires only inside plane 13, exactly 150 ticks before that plane ends. It never fires inside planes 0 to 12.
- R6: A frame accepted during a sequence leaves the remaining planes of that sequence unchanged. It first appears at the next start of plane 0.
- R7: If more than one frame is accepted before the next start of plane 0, the most recently accepted frame is the one shown from that point.
- R8: While `tick` is low, the sequence is frozen: no strobe, no trigger, and `plane_out` holds. Plane durations count only cycles with `tick` high.
- R9: After reset the sequencer is parked, with `plane_out` at zero and no strobe. On the first tick after the first frame has been transposed, it starts with plane 0 of that frame.
- R10: While reset is asserted, `plane_out`, `strobe` and `adc_trig` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer tick enable for all sequencing |
| in_valid | input | 1 | Frame valid |
| in_ready | output | 1 | Frame can be accepted |
| in_data | input | 512 | 32 brightness words of 16 bits, word j at bits 16j+15:16j |
| plane_out | output | 32 | Active bit-plane, bit j drives channel j |
| strobe | output | 1 | One-cycle latch pulse when a new plane appears |
| adc_trig | output | 1 | One-cycle measurement pretrigger inside the longest plane |

## Verification
The bench loads a frame in the middle of a sequence and checks that planes 6 to 13 still come from the old frame. A design that swapped immediately would show a torn mix of two frames. It sends two frames back to back before a wrap and expects the second. A design that latched the first transpose and dropped later ones would keep stale data. One frame sets only the two ignored low bits, so any design that picked the wrong bit column would light channels that must stay dark. Every plane interval and the gap from trigger to the following strobe are measured in cycles, including a stretch with `tick` held low. This catches off-by-one plane lengths, a trigger placed at the wrong count or in a short plane, and counters that run without ticks.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic {
    SEQ_PARKED = 1'b0,
    SEQ_RUN    = 1'b1
  } seq_state_e;

  // Bits needed to hold values 0 .. n-1, never less than one.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bcm_frame_in.sv
module bcm_frame_in #(
  parameter int NCH = 32,
  parameter int WIN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NCH*WIN-1:0] in_data,
  input  logic               consume,
  input  logic               busy,
  output logic               pending,
  output logic [NCH*WIN-1:0] frame_q
);
  localparam int FW = NCH * WIN;

  logic take;

  // The stored words stay untouched until the transposer has read them all.
  assign in_ready = !(pending || busy);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      frame_q <= {FW{1'b0}};
    end else if (take) begin
      frame_q <= in_data;
      pending <= 1'b1;
    end else if (consume) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/bcm_transposer.sv
module bcm_transposer
  import bcm_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int WIN    = 16,
  parameter int NPLANE = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pending,
  input  logic [NCH*WIN-1:0]           frame_q,
  input  logic                         swap_take,
  output logic                         start,
  output logic                         busy,
  output logic                         shadow_full,
  output logic [NPLANE-1:0][NCH-1:0]   shadow
);
  localparam int DROP = WIN - NPLANE;
  localparam int IW   = idx_bits(NPLANE);
  localparam logic [IW-1:0] LAST = IW'(NPLANE - 1);

  logic [NPLANE-1:0][NCH-1:0] col;
  logic [IW-1:0]              idx;
  logic [NCH-1:0]             unused_drop;

  // Column gi gathers bit (gi + DROP) of every channel word.
  for (genvar gi = 0; gi < NPLANE; gi++) begin : g_plane
    for (genvar gj = 0; gj < NCH; gj++) begin : g_chan
      assign col[gi][gj] = frame_q[gj*WIN + DROP + gi];
    end
  end

  if (DROP > 0) begin : g_drop
    for (genvar gj = 0; gj < NCH; gj++) begin : g_low
      assign unused_drop[gj] = ^frame_q[gj*WIN +: DROP];
    end
  end else begin : g_nodrop
    assign unused_drop = '0;
  end

  assign start = pending && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      idx         <= '0;
      shadow_full <= 1'b0;
      shadow      <= '0;
    end else if (start) begin
      busy        <= 1'b1;
      idx         <= '0;
      shadow_full <= 1'b0;
    end else if (busy) begin
      shadow[idx] <= col[idx];
      if (idx == LAST) begin
        busy        <= 1'b0;
        shadow_full <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (swap_take) begin
      shadow_full <= 1'b0;
    end
  end

endmodule

// File: rtl/bcm_sequencer.sv
module bcm_sequencer
  import bcm_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int NPLANE = 14,
  parameter int BASE   = 4,
  parameter int PRE    = 150
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             shadow_full,
  input  logic [NPLANE-1:0][NCH-1:0]       shadow,
  output logic                             swap_take,
  output logic [NCH-1:0]                   plane_out,
  output logic                             strobe,
  output logic                             trig,
  output logic [idx_bits(NPLANE)-1:0]      cur_idx
);
  localparam int IW   = idx_bits(NPLANE);
  localparam int LMAX = BASE << (NPLANE - 1);
  localparam int CW   = idx_bits(LMAX);
  localparam logic [IW-1:0] LAST    = IW'(NPLANE - 1);
  localparam logic [CW-1:0] TRIG_AT = CW'(LMAX - PRE - 1);

  seq_state_e                 state;
  logic [IW-1:0]              p;
  logic [CW-1:0]              cnt;
  logic [CW-1:0]              end_val;
  logic [NPLANE-1:0][NCH-1:0] active;
  logic                       at_end;
  logic                       swap_pt;

  assign end_val   = CW'((BASE << p) - 1);
  assign at_end    = (state == SEQ_RUN) && tick && (cnt == end_val);
  assign swap_pt   = tick && ((state == SEQ_PARKED) || (at_end && (p == LAST)));
  assign swap_take = swap_pt && shadow_full;
  assign cur_idx   = p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_PARKED;
      p         <= '0;
      cnt       <= '0;
      active    <= '0;
      plane_out <= '0;
      strobe    <= 1'b0;
      trig      <= 1'b0;
    end else begin
      strobe <= 1'b0;
      trig   <= 1'b0;
      if (swap_take) begin
        active    <= shadow;
        plane_out <= shadow[0];
      end
      if (state == SEQ_PARKED) begin
        if (swap_take) begin
          state  <= SEQ_RUN;
          p      <= '0;
          cnt    <= '0;
          strobe <= 1'b1;
        end
      end else if (tick) begin
        if (cnt == end_val) begin
          cnt    <= '0;
          strobe <= 1'b1;
          if (p == LAST) begin
            p <= '0;
            if (!swap_take) plane_out <= active[0];
          end else begin
            p         <= p + 1'b1;
            plane_out <= active[p + 1'b1];
          end
        end else begin
          cnt <= cnt + 1'b1;
          if ((p == LAST) && (cnt == TRIG_AT)) trig <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bcm_driver.sv
module bcm_driver
  import bcm_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int WIN    = 16,
  parameter int NPLANE = 14,
  parameter int BASE   = 4,
  parameter int PRE    = 150
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NCH*WIN-1:0] in_data,
  output logic [NCH-1:0]     plane_out,
  output logic               strobe,
  output logic               adc_trig
);
  localparam int IW = idx_bits(NPLANE);

  logic                       pending;
  logic [NCH*WIN-1:0]         frame_q;
  logic                       start;
  logic                       xp_busy;
  logic                       shadow_full;
  logic [NPLANE-1:0][NCH-1:0] shadow;
  logic                       swap_take;
  logic [IW-1:0]              seq_idx;

  bcm_frame_in #(.NCH(NCH), .WIN(WIN)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .consume  (start),
    .busy     (xp_busy),
    .pending  (pending),
    .frame_q  (frame_q)
  );

  bcm_transposer #(.NCH(NCH), .WIN(WIN), .NPLANE(NPLANE)) u_xp (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending     (pending),
    .frame_q     (frame_q),
    .swap_take   (swap_take),
    .start       (start),
    .busy        (xp_busy),
    .shadow_full (shadow_full),
    .shadow      (shadow)
  );

  bcm_sequencer #(.NCH(NCH), .NPLANE(NPLANE), .BASE(BASE), .PRE(PRE)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .shadow_full (shadow_full),
    .shadow      (shadow),
    .swap_take   (swap_take),
    .plane_out   (plane_out),
    .strobe      (strobe),
    .trig        (adc_trig),
    .cur_idx     (seq_idx)
  );

endmodule

// File: rtl/bcm_driver_chk.sv
module bcm_driver_chk
  import bcm_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int NPLANE = 14
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [NCH-1:0]              plane_out,
  input logic                        strobe,
  input logic                        adc_trig,
  input logic                        xp_busy,
  input logic                        swap_take,
  input logic [idx_bits(NPLANE)-1:0] seq_idx
);

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R4
  plane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(plane_out) |-> strobe);

  // R5
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);

  // R5
  trig_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> (seq_idx == NPLANE - 1));

  // R1
  accept_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6
  swap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_take |-> !xp_busy);

  // R6
  swap_plane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_take |=> (strobe && (seq_idx == '0)));

endmodule

bind bcm_driver bcm_driver_chk #(.NCH(NCH), .NPLANE(NPLANE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .plane_out (plane_out),
  .strobe    (strobe),
  .adc_trig  (adc_trig),
  .xp_busy   (xp_busy),
  .swap_take (swap_take),
  .seq_idx   (seq_idx)
);

// File: tb/tb_bcm_driver.sv
`timescale 1ns/1ps
module tb_bcm_driver;
  localparam int NCH = 32;
  localparam int WIN = 16;
  localparam int NP  = 14;
  localparam int WD  = 195000;

  // Stimulus table: word j of entry k = BASE_T[k] ^ (STEP_T[k] * j).
  localparam int NENT = 4;
  localparam logic [15:0] BASE_T [NENT] = '{16'hA5A7, 16'h0003, 16'h1234, 16'hFFFC};
  localparam logic [15:0] STEP_T [NENT] = '{16'h3C05, 16'h0000, 16'h0F11, 16'h4025};

  logic clk = 1'b0;
  logic rst_n, tick, in_valid, in_ready, strobe, adc_trig;
  logic [NCH*WIN-1:0] in_data;
  logic [NCH-1:0] plane_out;

  int checks = 0, fails = 0, cyc = 0;
  int trig_cnt = 0, last_trig = -1, prev = 0, tc0 = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcm_driver dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .plane_out(plane_out), .strobe(strobe), .adc_trig(adc_trig)
  );

  function automatic logic [15:0] word_of(input int k, input int j);
    logic [15:0] m;
    m = 16'(STEP_T[k] * j);
    return BASE_T[k] ^ m;
  endfunction

  function automatic logic [NCH-1:0] exp_plane(input int k, input int i);
    logic [NCH-1:0] e;
    for (int j = 0; j < NCH; j++) begin
      logic [15:0] w;
      w = word_of(k, j);
      e[j] = w[i + 2];
    end
    return e;
  endfunction

  function automatic logic [NCH*WIN-1:0] frame_of(input int k);
    logic [NCH*WIN-1:0] f;
    for (int j = 0; j < NCH; j++) f[j*WIN +: WIN] = word_of(k, j);
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(input int k);
    in_data  = frame_of(k);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_strobe();
    do begin
      @(negedge clk);
      if (adc_trig) begin
        trig_cnt++;
        last_trig = cyc;
      end
    end while (!strobe);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, fails);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=%0d expected below %0d cycles", cyc, WD);
    summary();
    $finish;
  end

  initial begin
    int n;
    bit ok;
    rst_n = 1'b0; tick = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(plane_out == '0 && !strobe && !adc_trig && in_ready, "R10", "reset outputs",
        {plane_out[28:0], strobe, adc_trig, in_ready}, 32'h1);
    rst_n = 1'b1; tick = 1'b1;
    // R9 parked without a frame
    ok = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (strobe || plane_out != '0) ok = 1'b0;
    end
    chk(ok, "R9", "parked before first frame", {31'b0, ok}, 32'h1);

    // R1 ready low window after accept
    load(0);
    n = 0;
    while (!in_ready) begin n++; @(negedge clk); end
    chk(n == NP + 1, "R1", "ready low cycles", n, NP + 1);
    @(negedge clk);
    chk(strobe == 1'b1, "R9", "start on first tick after transpose", strobe, 1);
    prev = cyc; tc0 = trig_cnt;

    // Table walk: one full sequence per entry.
    for (int k = 0; k < 2; k++) begin
      chk(plane_out == exp_plane(k, 0), "R2", "plane 0 content", plane_out, exp_plane(k, 0));
      for (int p = 1; p < NP; p++) begin
        wait_strobe();
        chk(cyc - prev == (4 << (p - 1)), "R3", "plane length", cyc - prev, 4 << (p - 1));
        prev = cyc;
        // R6 planes after a mid-sequence load still belong to the old frame
        chk(plane_out == exp_plane(k, p), (p > 5) ? "R6" : "R2", "plane content",
            plane_out, exp_plane(k, p));
        chk(trig_cnt == tc0, "R5", "no trigger in short planes", trig_cnt, tc0);
        if (p == 5) load(k == 0 ? 1 : 2);
        if (p == 7 && k == 1) load(3);
      end
      wait_strobe();
      chk(cyc - prev == (4 << (NP - 1)), "R3", "longest plane and wrap", cyc - prev, 4 << (NP - 1));
      chk(trig_cnt == tc0 + 1, "R5", "one trigger per sequence", trig_cnt, tc0 + 1);
      chk(cyc - last_trig == 150, "R5", "trigger lead", cyc - last_trig, 150);
      prev = cyc; tc0 = trig_cnt;
    end

    // R7 newest of two frames wins
    chk(plane_out == exp_plane(3, 0), "R7", "latest frame plane 0", plane_out, exp_plane(3, 0));
    wait_strobe();
    chk(cyc - prev == 4, "R3", "plane 0 after swap", cyc - prev, 4);
    prev = cyc;
    chk(plane_out == exp_plane(3, 1), "R7", "latest frame plane 1", plane_out, exp_plane(3, 1));

    // R8 tick gating
    tick = 1'b0;
    ok = 1'b1;
    begin
      logic [NCH-1:0] held;
      held = plane_out;
      repeat (20) begin
        @(negedge clk);
        if (strobe || adc_trig || plane_out != held) ok = 1'b0;
      end
    end
    tick = 1'b1;
    chk(ok, "R8", "frozen while tick low", {31'b0, ok}, 32'h1);
    wait_strobe();
    chk(cyc - prev == 28, "R8", "only ticks counted", cyc - prev, 28);
    chk(plane_out == exp_plane(3, 2), "R8", "plane after gating", plane_out, exp_plane(3, 2));

    // R10 reset mid-run, R9 parked again
    rst_n = 1'b0;
    @(negedge clk);
    chk(plane_out == '0 && !strobe && !adc_trig && in_ready, "R10", "mid-run reset",
        {plane_out[28:0], strobe, adc_trig, in_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    ok = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (strobe || plane_out != '0) ok = 1'b0;
    end
    chk(ok, "R9", "parked after reset", {31'b0, ok}, 32'h1);
    load(2);
    n = 0;
    while (!in_ready) begin n++; @(negedge clk); end
    chk(n == NP + 1, "R1", "ready low cycles after reset", n, NP + 1);
    @(negedge clk);
    chk(strobe && plane_out == exp_plane(2, 0), "R9", "restart with plane 0",
        plane_out, exp_plane(2, 0));

    summary();
    $finish;
  end
endmodule